// File: doc/BRIEF.md
# Nibble-Bus Timer with Tone and Buzzer Output

This block is a 4-bit down-counter with a small buzzer driver. A CPU reaches it over a 4-bit data bus at two nibble addresses. One address returns the live count on a read and takes a new reload value on a write. The other address is a write-only control nibble. The control nibble starts or stops the counter and chooses its clock source. It also chooses what the buzzer pins carry.

In timer mode the counter steps on a 1 Hz tick or on rising edges of an external input pin. In tone mode it steps on the oscillator tick, at full rate or at half rate. Its underflows then toggle a tone whose period is set by the reload value. In buzzer mode a fixed alarm square wave, 4 kHz or 2 kHz by parameter, appears on the pins only while a beep-enable input is high.

The two buzzer pins always carry complementary levels when driven, and both sit low when idle. Every underflow also sets a sticky flag, which a read of the count clears.

Top module: `nib_tone_timer`

## Requirements
- R1: After reset the control nibble is 0 (stopped, buzzer mode), count and reload are 0, rdata is 0, uf_flag is 0 and both buzzer pins are low.
- R2: A write to address 0xC sets both the reload value and the count to wdata on the next edge. A read of 0xC places the count on rdata one clock after rd_en.
- R3: Address 0xD is write-only control: bit 3 is run, bit 2 is timer source, bit 1 is tone rate, bit 0 is mode (1 tone, 0 buzzer). A read of 0xD or of any other address returns 0 and changes nothing.
- R4: While run is 1, each selected clock event decrements the count by one. While run is 0, the count holds.
- R5: An event while the count is 0 reloads the count from the reload value and sets uf_flag. A read of 0xC clears uf_flag.
- R6: In timer mode, bit 2 = 1 counts rising edges of ext_in after a two-flop synchroniser, and bit 2 = 0 counts tick_1hz pulses. osc_tick has no effect on the count in timer mode.
- R7: In tone mode, bit 1 = 1 counts every osc_tick pulse, and bit 1 = 0 counts every second osc_tick pulse. tick_1hz and ext_in have no effect on the count in tone mode.
- R8: In tone mode with run = 1, the tone level toggles on each underflow, buzz_p carries the tone and buzz_n its complement. With run = 0, both pins are low.
- R9: In buzzer mode the alarm level toggles every ALARM_HALF osc_tick pulses (4 at the default 4 kHz setting). buzz_p and buzz_n carry the alarm and its complement while beep_en is 1, and both are low while beep_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 4 | Nibble address |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Registered read data |
| beep_en | input | 1 | Beep enable bit for buzzer mode |
| tick_1hz | input | 1 | One-cycle 1 Hz tick pulse |
| ext_in | input | 1 | Asynchronous external count input |
| osc_tick | input | 1 | One-cycle oscillator tick pulse |
| uf_flag | output | 1 | Sticky underflow flag |
| buzz_p | output | 1 | Buzzer pin, true phase |
| buzz_n | output | 1 | Buzzer pin, complement phase |

## Verification
The hardest state to reach from the ports is an underflow that toggles the tone while the half-rate oscillator divider is mid-phase. Reaching it needs the reload value, the divider phase and the run bit to line up. A bench model tracks the divider phase across every oscillator pulse, including pulses in timer or stopped states. Seeded random stimulus then mixes control writes, reloads, every event kind and reads, so that underflows land in each mode and phase. Directed cases first cover a reload of 0, the external-edge path through the synchroniser, and inputs that should be ignored.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  // Control nibble, bit 3 down to bit 0.
  typedef struct packed {
    logic run;        // 1 = counting
    logic ext_sel;    // timer mode: 1 = external pin, 0 = 1 Hz tick
    logic fast_sel;   // tone mode: 1 = every osc tick, 0 = every second
    logic tone_mode;  // 1 = tone, 0 = alarm buzzer
  } ctl_t;
endpackage

// File: rtl/nbt_regs.sv
module nbt_regs
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 4'hC,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 4'hD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count,
  output ctl_t              ctl,
  output logic              load,
  output logic [DATA_W-1:0] load_val,
  output logic              rd_clear,
  output logic [DATA_W-1:0] rdata
);
  logic hit_cnt, hit_ctl;
  ctl_t ctl_q;
  logic [DATA_W-1:0] rdata_q;

  assign hit_cnt  = (addr == CNT_ADDR);
  assign hit_ctl  = (addr == CTL_ADDR);
  assign load     = wr_en & hit_cnt;
  assign load_val = wdata;
  assign rd_clear = rd_en & hit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_en && hit_ctl) begin
      ctl_q <= ctl_t'(wdata[3:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= hit_cnt ? count : '0;
    end
  end

  assign ctl   = ctl_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/nbt_evsel.sv
module nbt_evsel
  import nbt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ALARM_HALF  = 4
) (
  input  logic clk,
  input  logic rst,
  input  ctl_t ctl,
  input  logic tick_1hz,
  input  logic ext_in,
  input  logic osc_tick,
  output logic cnt_ev,
  output logic alarm_q
);
  localparam int AW = (ALARM_HALF > 1) ? $clog2(ALARM_HALF) : 1;
  localparam logic [AW-1:0] ALARM_LAST = AW'(ALARM_HALF - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic ext_prev, ext_rise;
  logic half_q;
  logic [AW-1:0] acnt_q;
  logic alarm_r;
  logic timer_ev, tone_ev;

  // Synchroniser chain for the asynchronous pin.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '0;
      ext_prev <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], ext_in};
      ext_prev <= sync_q[SYNC_STAGES-1];
    end
  end
  assign ext_rise = sync_q[SYNC_STAGES-1] & ~ext_prev;

  // Half-rate phase and alarm divider run on every oscillator tick.
  always_ff @(posedge clk) begin
    if (rst) begin
      half_q  <= 1'b0;
      acnt_q  <= '0;
      alarm_r <= 1'b0;
    end else if (osc_tick) begin
      half_q <= ~half_q;
      if (acnt_q == ALARM_LAST) begin
        acnt_q  <= '0;
        alarm_r <= ~alarm_r;
      end else begin
        acnt_q <= acnt_q + 1'b1;
      end
    end
  end

  assign timer_ev = ctl.ext_sel ? ext_rise : tick_1hz;
  assign tone_ev  = osc_tick & (ctl.fast_sel | half_q);
  assign cnt_ev   = ctl.run & (ctl.tone_mode ? tone_ev : timer_ev);
  assign alarm_q  = alarm_r;
endmodule

// File: rtl/nbt_counter.sv
module nbt_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ev,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         rd_clear,
  output logic [W-1:0] count,
  output logic [W-1:0] reload,
  output logic         uf_pulse,
  output logic         flag
);
  logic [W-1:0] cnt_q, rld_q;
  logic flag_q, wrap;

  assign wrap = ev & ~load & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
      rld_q <= load_val;
    end else if (ev) begin
      cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - 1'b1;
    end
  end

  // A set in the same cycle as a clearing read wins.
  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else if (wrap) flag_q <= 1'b1;
    else if (rd_clear) flag_q <= 1'b0;
  end

  assign count    = cnt_q;
  assign reload   = rld_q;
  assign uf_pulse = wrap;
  assign flag     = flag_q;
endmodule

// File: rtl/nbt_outstage.sv
module nbt_outstage
  import nbt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_t ctl,
  input  logic beep_en,
  input  logic uf_pulse,
  input  logic alarm_q,
  output logic buzz_p,
  output logic buzz_n
);
  logic tone_q, active, src, p_q, n_q;

  always_ff @(posedge clk) begin
    if (rst) tone_q <= 1'b0;
    else if (uf_pulse && ctl.tone_mode) tone_q <= ~tone_q;
  end

  assign active = ctl.tone_mode ? ctl.run : beep_en;
  assign src    = ctl.tone_mode ? tone_q : alarm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q <= 1'b0;
      n_q <= 1'b0;
    end else begin
      p_q <= active & src;
      n_q <= active & ~src;
    end
  end

  assign buzz_p = p_q;
  assign buzz_n = n_q;
endmodule

// File: rtl/nib_tone_timer.sv
module nib_tone_timer
  import nbt_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 4,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 4'hC,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 4'hD,
  parameter int SYNC_STAGES = 2,
  parameter int OSC_DIV_4K  = 8,
  parameter bit ALARM_HI    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              beep_en,
  input  logic              tick_1hz,
  input  logic              ext_in,
  input  logic              osc_tick,
  output logic              uf_flag,
  output logic              buzz_p,
  output logic              buzz_n
);
  localparam int ALARM_HALF = ALARM_HI ? OSC_DIV_4K / 2 : OSC_DIV_4K;

  ctl_t ctl_w;
  logic load_w, rd_clear_w, cnt_ev_w, uf_pulse_w, alarm_w;
  logic [DATA_W-1:0] load_val_w, count_w, reload_w;

  nbt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_ADDR(CNT_ADDR), .CTL_ADDR(CTL_ADDR)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .count(count_w), .ctl(ctl_w), .load(load_w), .load_val(load_val_w),
    .rd_clear(rd_clear_w), .rdata(rdata));

  nbt_evsel #(.SYNC_STAGES(SYNC_STAGES), .ALARM_HALF(ALARM_HALF)) evsel_i (
    .clk(clk), .rst(rst), .ctl(ctl_w), .tick_1hz(tick_1hz), .ext_in(ext_in),
    .osc_tick(osc_tick), .cnt_ev(cnt_ev_w), .alarm_q(alarm_w));

  nbt_counter #(.W(DATA_W)) cnt_i (
    .clk(clk), .rst(rst), .ev(cnt_ev_w), .load(load_w), .load_val(load_val_w),
    .rd_clear(rd_clear_w), .count(count_w), .reload(reload_w),
    .uf_pulse(uf_pulse_w), .flag(uf_flag));

  nbt_outstage out_i (
    .clk(clk), .rst(rst), .ctl(ctl_w), .beep_en(beep_en), .uf_pulse(uf_pulse_w),
    .alarm_q(alarm_w), .buzz_p(buzz_p), .buzz_n(buzz_n));
endmodule

// File: rtl/nib_tone_timer_chk.sv
module nib_tone_timer_chk
  import nbt_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 4'hC
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] reload,
  input logic              ev,
  input logic              load,
  input ctl_t              ctl,
  input logic              beep_en,
  input logic              uf_flag,
  input logic              buzz_p,
  input logic              buzz_n
);
  // R8
  pins_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(buzz_p && buzz_n));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (ev && !load && count != '0) |=> (count == $past(count) - 1'b1));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ev && !load) |=> $stable(count));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ev && !load && count == '0) |=> (count == $past(reload) && uf_flag));

  // R3
  other_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != CNT_ADDR) |=> (rdata == '0));

  // R2
  count_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == CNT_ADDR) |=> (rdata == $past(count)));

  // R9
  beep_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.tone_mode && !beep_en) |=> (!buzz_p && !buzz_n));

  // R8
  tone_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.tone_mode && !ctl.run) |=> (!buzz_p && !buzz_n));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CNT_ADDR) |=> (count == reload));
endmodule

bind nib_tone_timer nib_tone_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_ADDR(CNT_ADDR)) chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .count(count_w), .reload(reload_w), .ev(cnt_ev_w), .load(load_w), .ctl(ctl_w),
  .beep_en(beep_en), .uf_flag(uf_flag), .buzz_p(buzz_p), .buzz_n(buzz_n));

// File: tb/nib_tone_timer_tb_top.sv
module nib_tone_timer_tb_top;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0, beep_en = 0, tick_1hz = 0, ext_in = 0, osc_tick = 0;
  logic [3:0] addr = 0, wdata = 0;
  logic [3:0] rdata;
  logic uf_flag, buzz_p, buzz_n;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [3:0] m_cnt = 0, m_rld = 0, m_ctl = 0;
  logic m_flag = 0, m_half = 0, m_tone = 0, m_alarm = 0;
  int m_acnt = 0;

  always #5 clk = ~clk;

  nib_tone_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .beep_en(beep_en), .tick_1hz(tick_1hz), .ext_in(ext_in),
    .osc_tick(osc_tick), .uf_flag(uf_flag), .buzz_p(buzz_p), .buzz_n(buzz_n));

  function automatic logic [3:0] next_cnt(input logic [3:0] c, input logic [3:0] r);
    return (c == 4'd0) ? r : c - 4'd1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic model_event();
    if (m_cnt == 4'd0) begin
      m_flag = 1'b1;
      if (m_ctl[0]) m_tone = ~m_tone;
    end
    m_cnt = next_cnt(m_cnt, m_rld);
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    if (a == 4'hC) begin m_cnt = d; m_rld = d; end
    if (a == 4'hD) m_ctl = d;
  endtask

  task automatic rd(input logic [3:0] a, output logic [3:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rdata;
    if (a == 4'hC) m_flag = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    if (m_ctl[3] && !m_ctl[0] && !m_ctl[2]) model_event();
  endtask

  task automatic pulse_osc();
    @(negedge clk); osc_tick = 1;
    @(negedge clk); osc_tick = 0;
    if (m_ctl[3] && m_ctl[0] && (m_ctl[1] || m_half)) model_event();
    m_half = ~m_half;
    if (m_acnt == HALF - 1) begin m_acnt = 0; m_alarm = ~m_alarm; end
    else m_acnt++;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_in = 1;
    idle(4);
    ext_in = 0;
    idle(4);
    if (m_ctl[3] && !m_ctl[0] && m_ctl[2]) model_event();
  endtask

  task automatic chk_pins(input string req);
    logic act, src;
    idle(1);
    act = m_ctl[0] ? m_ctl[3] : beep_en;
    src = m_ctl[0] ? m_tone : m_alarm;
    chk(req, {buzz_p, buzz_n}, {act & src, act & ~src});
  endtask

  task automatic chk_count(input string req);
    logic [3:0] v;
    chk(req, uf_flag, m_flag);
    rd(4'hC, v);
    chk(req, v, m_cnt);
    chk(req, uf_flag, 0);
  endtask

  initial begin
    logic [3:0] v;
    int seed;
    seed = $urandom(32'h1F2E3D4C);
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 pins", {buzz_p, buzz_n}, 0);
    chk("R1 flag", uf_flag, 0);
    rd(4'hC, v); chk("R1 count", v, 0);

    // R2 load and read back
    wr(4'hC, 4'd9);
    rd(4'hC, v); chk("R2 readback", v, 9);
    // R3 read of control address returns 0, count untouched
    wr(4'hD, 4'h8);
    rd(4'hD, v); chk("R3 ctl read", v, 0);
    rd(4'h3, v); chk("R3 other read", v, 0);
    rd(4'hC, v); chk("R3 count unchanged", v, 9);

    // R4 run with 1 Hz ticks, R6 osc ignored in timer mode
    pulse_tick(); pulse_tick();
    chk_count("R4 two ticks");
    pulse_osc(); pulse_osc();
    chk_count("R6 osc ignored in timer");
    wr(4'hD, 4'h0);
    pulse_tick();
    chk_count("R4 stopped holds");

    // R5 reload of 0 wraps on every event
    wr(4'hC, 4'd0);
    wr(4'hD, 4'h8);
    pulse_tick();
    chk("R5 flag set", uf_flag, 1);
    chk_count("R5 wrap from zero");
    wr(4'hC, 4'd1);
    pulse_tick(); pulse_tick();
    chk_count("R5 wrap to reload");

    // R6 external edge source, tick ignored
    wr(4'hC, 4'd5);
    wr(4'hD, 4'hC);
    pulse_ext(); pulse_ext();
    pulse_tick();
    chk_count("R6 ext edges");

    // R7/R8 tone mode full rate, reload 2
    wr(4'hC, 4'd2);
    wr(4'hD, 4'hB);
    chk_pins("R8 tone start");
    pulse_osc(); pulse_osc(); pulse_osc();
    chk_pins("R8 tone toggled");
    pulse_tick();
    chk_count("R7 tick ignored in tone");
    // R7 half rate
    wr(4'hD, 4'h9);
    for (int i = 0; i < 5; i++) pulse_osc();
    chk_count("R7 half rate");
    chk_pins("R8 half rate pins");
    wr(4'hD, 4'h1);
    chk_pins("R8 stopped low");

    // R9 alarm buzzer
    wr(4'hD, 4'h0);
    beep_en = 1;
    chk_pins("R9 beep on");
    for (int i = 0; i < HALF; i++) pulse_osc();
    chk_pins("R9 alarm toggle");
    for (int i = 0; i < HALF - 1; i++) pulse_osc();
    chk_pins("R9 alarm mid");
    beep_en = 0;
    chk_pins("R9 beep off");

    // random mix
    beep_en = 1;
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: wr(4'hD, 4'($urandom_range(0, 15)));
        1: wr(4'hC, 4'($urandom_range(0, 15)));
        2, 3: pulse_tick();
        4, 5, 6: pulse_osc();
        7: pulse_ext();
        8: chk_count("R4 R5 random count");
        default: begin
          beep_en = 1'($urandom_range(0, 1));
          chk_pins("R8 R9 random pins");
        end
      endcase
    end
    chk_count("R4 final count");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule